// File: doc/BRIEF.md
# PLL Output Frequency Calculator

This block works out the output frequency of a phase-locked loop from the packed contents of its divider control word and the frequency of its reference clock. It supports two loop types. The integer type uses only a feedback multiplier, a pre-divider and a power-of-two post-divider. The fractional type also takes a signed 16-bit fraction that refines the feedback multiplier in steps of 1/65536.

A caller presents the divider word, the fractional word, the reference frequency and the loop type, then pulses `start` while the block is idle. The block captures the operands and forms a 64-bit numerator and denominator. It then runs a restoring divider that settles one quotient bit per clock. When the divider finishes, the truncated quotient appears on `freq_out` and `done` pulses for one cycle. A zero pre-divider cannot be divided by, so the block flags it at once and skips the divide.

Top module: `pll_freq_calc`

## Requirements
- R1: Field positions in `div_word`: feedback multiplier M = bits 21:12 (unsigned), pre-divider P = bits 9:4 (unsigned), post-divider exponent S = bits 2:0. No other bit of `div_word` affects the result.
- R2: With `frac_mode` = 0, the result is floor(ref_freq * M / (P << S)). `frac_word` has no effect in this mode.
- R3: With `frac_mode` = 1, the result is floor(ref_freq * (M*65536 + K) / ((P*65536) << S)), where K is `frac_word[15:0]` read as a two's-complement signed value.
- R4: In fractional mode, if M*65536 + K is negative, `freq_out` becomes 0 and `div_err` becomes 0. `done` pulses one clock after the start is accepted.
- R5: If P = 0, the block skips the divide. `div_err` becomes 1, `freq_out` becomes 0, and `done` pulses one clock after the start is accepted.
- R6: For every other accepted start, `done` rises after exactly 64 further clock edges following the accepting edge. It stays high for exactly one cycle.
- R7: A start is accepted only when `busy` is low. `busy` is high from the accepting edge through the cycle in which `done` is high. A `start` pulse seen while `busy` is high is ignored.
- R8: `freq_out` and `div_err` change only in the cycle where `done` goes high. They hold their values until the next result.
- R9: All operands are captured at the accepting edge. Changing the inputs afterwards does not alter the result.
- R10: After reset, `busy`, `done` and `div_err` are 0 and `freq_out` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request a calculation (accepted only when idle) |
| frac_mode | input | 1 | 0: integer loop type, 1: fractional loop type |
| div_word | input | 32 | Packed divider control word |
| frac_word | input | 16 | Signed fraction K |
| ref_freq | input | 32 | Reference frequency |
| busy | output | 1 | Calculation in progress or result cycle |
| done | output | 1 | One-cycle result strobe |
| div_err | output | 1 | Last result came from a zero pre-divider |
| freq_out | output | 64 | Truncated output frequency |

## Verification
Suppose the divider's iteration counter or its partial remainder goes wrong. The effect shows on `freq_out` or on the timing of `done` at the end of the 64-cycle run, with a wrong value or an early or late strobe. The bench compares `busy` and `done` with its model on every clock, so a timing fault is caught in the cycle it appears. A fault in field extraction or in the signed fraction fold gives a wrong quotient for vectors chosen to exercise each field and both signs of K. A fault in the accept logic shows up when a mid-run `start` or an input change after acceptance alters the held result.

// File: rtl/pll_freq_pkg.sv
package pll_freq_pkg;
    localparam int FIN_W   = 32;
    localparam int QUO_W   = 64;
    localparam int WORD_W  = 32;
    localparam int FRAC_W  = 16;
    localparam int M_LSB   = 12;
    localparam int M_W     = 10;
    localparam int P_LSB   = 4;
    localparam int P_W     = 6;
    localparam int S_LSB   = 0;
    localparam int S_W     = 3;
    localparam int MULT_W  = M_W + FRAC_W + 2;
    localparam int CNT_W   = $clog2(QUO_W + 1);

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } calc_state_e;
endpackage

// File: rtl/pll_operand_build.sv
module pll_operand_build
    import pll_freq_pkg::*;
(
    input  logic              frac_mode,
    input  logic [WORD_W-1:0] div_word,
    input  logic [FRAC_W-1:0] frac_word,
    input  logic [FIN_W-1:0]  ref_freq,
    output logic [QUO_W-1:0]  numer,
    output logic [QUO_W-1:0]  denom,
    output logic              pre_zero,
    output logic              mult_neg
);
    logic [M_W-1:0]    m_f;
    logic [P_W-1:0]    p_f;
    logic [S_W-1:0]    s_f;
    logic [MULT_W-1:0] mult_frac;
    logic [MULT_W-1:0] mult_sel;
    logic [QUO_W-1:0]  den_base;

    always_comb begin
        m_f       = div_word[M_LSB +: M_W];
        p_f       = div_word[P_LSB +: P_W];
        s_f       = div_word[S_LSB +: S_W];
        // fold the signed fraction into a 65536-scaled multiplier
        mult_frac = {2'b00, m_f, {FRAC_W{1'b0}}}
                  + {{(MULT_W-FRAC_W){frac_word[FRAC_W-1]}}, frac_word};
        mult_sel  = frac_mode ? mult_frac : {{(MULT_W-M_W){1'b0}}, m_f};
        mult_neg  = frac_mode & mult_frac[MULT_W-1];
        pre_zero  = (p_f == '0);
        den_base  = frac_mode ? {{(QUO_W-P_W-FRAC_W){1'b0}}, p_f, {FRAC_W{1'b0}}}
                              : {{(QUO_W-P_W){1'b0}}, p_f};
        denom     = den_base << s_f;
        numer     = QUO_W'(ref_freq) * QUO_W'(mult_sel);
    end
endmodule

// File: rtl/pll_restoring_div.sv
module pll_restoring_div
    import pll_freq_pkg::*;
#(
    parameter int W = QUO_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         last,
    output logic [W-1:0] quot_nxt
);
    localparam int CW = $clog2(W + 1);

    typedef struct packed {
        logic [W:0]    rem;
        logic [W-1:0]  quo;
        logic [W-1:0]  den;
        logic [CW-1:0] cnt;
        logic          run;
    } div_regs_t;

    div_regs_t r_q, r_d;
    logic [W:0] rem_sh;
    logic       ge;

    always_comb begin
        r_d      = r_q;
        rem_sh   = {r_q.rem[W-1:0], r_q.quo[W-1]};
        ge       = (rem_sh >= {1'b0, r_q.den});
        quot_nxt = {r_q.quo[W-2:0], ge};
        last     = r_q.run && (r_q.cnt == CW'(W - 1));
        if (load) begin
            r_d.rem = '0;
            r_d.quo = dividend;
            r_d.den = divisor;
            r_d.cnt = '0;
            r_d.run = 1'b1;
        end else if (r_q.run) begin
            r_d.rem = ge ? (rem_sh - {1'b0, r_q.den}) : rem_sh;
            r_d.quo = quot_nxt;
            r_d.cnt = r_q.cnt + 1'b1;
            if (last) r_d.run = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end
endmodule

// File: rtl/pll_freq_calc.sv
module pll_freq_calc
    import pll_freq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              frac_mode,
    input  logic [WORD_W-1:0] div_word,
    input  logic [FRAC_W-1:0] frac_word,
    input  logic [FIN_W-1:0]  ref_freq,
    output logic              busy,
    output logic              done,
    output logic              div_err,
    output logic [QUO_W-1:0]  freq_out
);
    typedef struct packed {
        calc_state_e      st;
        logic [QUO_W-1:0] res;
        logic             err;
    } top_regs_t;

    top_regs_t t_q, t_d;

    logic [QUO_W-1:0] numer, denom, quot_nxt;
    logic             pre_zero, mult_neg, div_last, div_load;

    pll_operand_build u_ops (
        .frac_mode (frac_mode),
        .div_word  (div_word),
        .frac_word (frac_word),
        .ref_freq  (ref_freq),
        .numer     (numer),
        .denom     (denom),
        .pre_zero  (pre_zero),
        .mult_neg  (mult_neg)
    );

    pll_restoring_div #(.W(QUO_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (div_load),
        .dividend (numer),
        .divisor  (denom),
        .last     (div_last),
        .quot_nxt (quot_nxt)
    );

    always_comb begin
        t_d      = t_q;
        div_load = 1'b0;
        unique case (t_q.st)
            ST_IDLE: begin
                if (start) begin
                    if (pre_zero) begin
                        t_d.st  = ST_DONE;
                        t_d.res = '0;
                        t_d.err = 1'b1;
                    end else if (mult_neg) begin
                        t_d.st  = ST_DONE;
                        t_d.res = '0;
                        t_d.err = 1'b0;
                    end else begin
                        div_load = 1'b1;
                        t_d.st   = ST_RUN;
                    end
                end
            end
            ST_RUN: begin
                if (div_last) begin
                    t_d.st  = ST_DONE;
                    t_d.res = quot_nxt;
                    t_d.err = 1'b0;
                end
            end
            ST_DONE: t_d.st = ST_IDLE;
            default: t_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '{st: ST_IDLE, res: '0, err: 1'b0};
        else        t_q <= t_d;
    end

    assign busy     = (t_q.st != ST_IDLE);
    assign done     = (t_q.st == ST_DONE);
    assign div_err  = t_q.err;
    assign freq_out = t_q.res;
endmodule

// File: rtl/pll_freq_calc_chk.sv
module pll_freq_calc_chk
    import pll_freq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WORD_W-1:0] div_word,
    input  logic              busy,
    input  logic              done,
    input  logic              div_err,
    input  logic [QUO_W-1:0]  freq_out
);
    logic [CNT_W:0] since_acc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              since_acc_q <= '0;
        else if (start && !busy) since_acc_q <= '0;
        else if (busy)           since_acc_q <= since_acc_q + 1'b1;
    end

    assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (since_acc_q == '0 || since_acc_q == (CNT_W+1)'(QUO_W)));

    assert_done_in_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    assert_zero_pre_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && div_word[P_LSB +: P_W] == '0) |=> (done && div_err && freq_out == '0));

    assert_result_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(freq_out) || !$stable(div_err)) |-> done);
endmodule

bind pll_freq_calc pll_freq_calc_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .div_word (div_word),
    .busy     (busy),
    .done     (done),
    .div_err  (div_err),
    .freq_out (freq_out)
);

// File: tb/tb_pll_freq_calc.sv
module tb_pll_freq_calc;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        frac_mode = 1'b0;
    logic [31:0] div_word = '0;
    logic [15:0] frac_word = '0;
    logic [31:0] ref_freq = '0;
    logic        busy, done, div_err;
    logic [63:0] freq_out;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    pll_freq_calc dut (
        .clk(clk), .rst_n(rst_n), .start(start), .frac_mode(frac_mode),
        .div_word(div_word), .frac_word(frac_word), .ref_freq(ref_freq),
        .busy(busy), .done(done), .div_err(div_err), .freq_out(freq_out)
    );

    task automatic check(input string req, input longint unsigned act, input longint unsigned exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [31:0] pack(input int m, input int p, input int s);
        return (32'(m) << 12) | (32'(p) << 4) | 32'(s);
    endfunction

    // run one case; disturb: pulse start with other operands mid-run
    task automatic run_case(input string req, input bit fm, input logic [31:0] dw,
                            input logic [15:0] kw, input logic [31:0] fin, input bit disturb);
        longint unsigned m, p, s, exp_q;
        longint mult;
        bit exp_err, fast;
        int lat;
        m = longint'(dw[21:12]);
        p = longint'(dw[9:4]);
        s = longint'(dw[2:0]);
        exp_err = 1'b0;
        fast = 1'b0;
        if (p == 0) begin
            exp_q = 0; exp_err = 1'b1; fast = 1'b1;
        end else if (fm) begin
            mult = longint'(m) * 65536 + longint'($signed(kw));
            if (mult < 0) begin
                exp_q = 0; fast = 1'b1;
            end else begin
                exp_q = (longint'(fin) * longint'(mult)) / ((p * 65536) << s);
            end
        end else begin
            exp_q = (longint'(fin) * m) / (p << s);
        end
        lat = fast ? 0 : 64;

        @(negedge clk);
        frac_mode = fm; div_word = dw; frac_word = kw; ref_freq = fin; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k <= lat + 1; k++) begin
            if (k > 0) @(negedge clk);
            if (disturb && k == 10) begin
                // R9: operands changed after capture; R7: start while busy
                start = 1'b1; div_word = pack(1, 1, 0); ref_freq = 32'd7;
                frac_mode = ~fm; frac_word = 16'h8000;
            end else begin
                start = 1'b0;
            end
            check({req, " R6 done timing"}, longint'(done), longint'(k == lat));
            check({req, " R7 busy"}, longint'(busy), longint'(k <= lat));
            if (k == lat) begin
                check({req, " result"}, freq_out, exp_q);
                check({req, " R5 err flag"}, longint'(div_err), longint'(exp_err));
            end
        end
        start = 1'b0;
        for (int h = 0; h < 3; h++) begin
            @(negedge clk);
            check({req, " R8 hold value"}, freq_out, exp_q);
            check({req, " R8 hold err"}, longint'(div_err), longint'(exp_err));
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R10 busy", longint'(busy), 0);
        check("R10 done", longint'(done), 0);
        check("R10 err", longint'(div_err), 0);
        check("R10 freq", freq_out, 0);
        rst_n = 1'b1;
        @(negedge clk);

        run_case("R2 int 225/3/0", 1'b0, pack(225, 3, 0), 16'h0, 32'd24_000_000, 1'b0);
        run_case("R2 int 375/3/1", 1'b0, pack(375, 3, 1), 16'h1234, 32'd24_000_000, 1'b0);
        run_case("R2 int 250/2/2", 1'b0, pack(250, 2, 2), 16'h0, 32'd24_000_000, 1'b0);
        run_case("R2 truncation", 1'b0, pack(1, 3, 0), 16'h0, 32'd1000, 1'b0);
        run_case("R2 max operands", 1'b0, pack(1023, 1, 0), 16'h0, 32'hFFFF_FFFF, 1'b0);
        run_case("R2 max shift", 1'b0, pack(700, 63, 7), 16'h0, 32'd123_456_789, 1'b0);
        run_case("R1 stray bits", 1'b0, pack(300, 3, 1) | 32'hFFC0_0C08, 16'h0, 32'd24_000_000, 1'b0);
        run_case("R3 frac pos K", 1'b1, pack(262, 2, 3), 16'd9437, 32'd24_000_000, 1'b0);
        run_case("R3 frac neg K", 1'b1, pack(361, 3, 3), 16'hEC78, 32'd24_000_000, 1'b0);
        run_case("R3 frac K min", 1'b1, pack(2, 1, 0), 16'h8000, 32'd1_000_000, 1'b0);
        run_case("R1 frac stray bits", 1'b1, pack(325, 3, 2) | 32'hFFC0_0C08, 16'd77, 32'd24_000_000, 1'b0);
        run_case("R4 neg multiplier", 1'b1, pack(0, 5, 1), 16'hFFFF, 32'd24_000_000, 1'b0);
        run_case("R5 zero pre-div int", 1'b0, pack(200, 0, 1), 16'h0, 32'd24_000_000, 1'b0);
        run_case("R5 zero pre-div frac", 1'b1, pack(0, 0, 0), 16'hFFFF, 32'd24_000_000, 1'b0);
        run_case("R7 R9 busy start", 1'b0, pack(350, 3, 2), 16'h0, 32'd24_000_000, 1'b1);
        run_case("R7 R9 busy start frac", 1'b1, pack(198, 2, 2), 16'd500, 32'd24_000_000, 1'b1);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: run did not complete actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule